// File: doc/BRIEF.md
# Interrupt Distributor Control Register Block

This block sits at the base of an interrupt distributor's register window. It holds three words. The first is a control word with a global enable bit. The second is a read-only type word that describes how large the distributor is. The third is a read-only identification word.

A 32-bit read/write port selects a register with two address bits. Reads return data one cycle after the strobe. Writes take effect at the clock edge that samples them.

The type word is not stored. It is computed at read time from two live configuration inputs: the number of shared interrupt lines and the number of processors that are online. When software switches the distributor from disabled to enabled, the block sends a single-cycle wake pulse to every processor interface. The downstream interfaces then re-evaluate what they have pending.

Top module: `dist_ctl_regs`

## Requirements
- R1: Only address bits [3:2] select the register: 0 is control, 1 is type, 2 is identification, 3 is reserved. All other address bits are ignored, so the word at byte offset 0x104 is the type word.
- R2: After reset, `dist_enable`, `wake_all` and `rsp_valid` are 0, and a read of control returns 0.
- R3: A write to control loads `dist_enable` from write-data bit 0 and ignores write-data bits [31:1]. A read of control returns the enable in bit 0 and zeros in bits [31:1].
- R4: A control write that takes the enable from 0 to 1 raises `wake_all` for exactly one cycle, starting in the same cycle that `dist_enable` first reads 1. A write of 1 while already enabled, or any write of 0, gives no pulse.
- R5: Type bits [4:0] equal ((`cfg_shared_lines` + 32) / 32) − 1, using integer division.
- R6: Type bits [7:5] equal `cfg_cpus_online` − 1, and type bits [31:8] read 0.
- R7: The identification word reads as {PRODUCT_CODE, 12'h000, IMPL_CODE}: the product code in bits [31:24], zeros in bits [23:12] and the implementer code in bits [11:0].
- R8: Writes to the type, identification or reserved words leave `dist_enable` unchanged and give no `wake_all` pulse.
- R9: A read of the reserved word (select 3) returns 0.
- R10: `rsp_valid` is 1 in the cycle after a read strobe, with `rsp_rdata` holding the selected word. A write strobe, or no strobe, leaves `rsp_valid` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| cfg_shared_lines | input | SHARED_W | Number of shared interrupt lines |
| cfg_cpus_online | input | CPU_W | Number of online processors (1 to 8) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| dist_enable | output | 1 | Global distributor enable |
| wake_all | output | 1 | One-cycle wake pulse to all processor interfaces |

## Verification
The assertions assume the following about the port:
- `req_write` is meaningful only while `req_valid` is high.
- Each access is a single strobe, with no back-pressure.
- `cfg_cpus_online` is never 0.

None of the properties depend on the configuration inputs, because the type word is checked by value at the ports.

The bench follows these rules when driving stimulus:
- It drives each strobe for exactly one cycle and idles between accesses.
- It keeps the processor count between 1 and 8.
- It holds the configuration inputs steady from the read strobe until the data is sampled. The data therefore reflects the values present at the strobe.

// File: rtl/dist_ctl_pkg.sv
package dist_ctl_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TYPE  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic        en;
        logic        wake;
        logic        rsp_valid;
        logic [31:0] rdata;
    } ctl_state_t;

    localparam int unsigned PRIV_LINES = 32;
    localparam int unsigned LINES_FW   = 5;
    localparam int unsigned CPU_FW     = 3;

endpackage

// File: rtl/dist_ctl_decode.sv
module dist_ctl_decode
    import dist_ctl_pkg::*;
(
    input  logic [1:0] word_sel,
    output reg_sel_e   sel
);

    always_comb begin
        sel = reg_sel_e'(word_sel);
    end

endmodule

// File: rtl/dist_ctl_typeval.sv
module dist_ctl_typeval
    import dist_ctl_pkg::*;
#(
    parameter int unsigned SHARED_W = 10,
    parameter int unsigned CPU_W    = 4
) (
    input  logic [SHARED_W-1:0] shared_lines,
    input  logic [CPU_W-1:0]    cpus_online,
    output logic [31:0]         type_word
);

    localparam int unsigned TOT_W = SHARED_W + 1;
    localparam int unsigned GRP_W = TOT_W - 5;

    logic [TOT_W-1:0]    total_lines;
    logic [GRP_W-1:0]    groups;
    logic [LINES_FW-1:0] lines_field;
    logic [CPU_FW-1:0]   cpu_field;

    always_comb begin
        total_lines = {1'b0, shared_lines} + TOT_W'(PRIV_LINES);
        groups      = total_lines[TOT_W-1:5];
        lines_field = LINES_FW'(groups - GRP_W'(1));
        cpu_field   = CPU_FW'(cpus_online - CPU_W'(1));
        type_word   = {{(32-LINES_FW-CPU_FW){1'b0}}, cpu_field, lines_field};
    end

endmodule

// File: rtl/dist_ctl_regs.sv
module dist_ctl_regs
    import dist_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned SHARED_W     = 10,
    parameter int unsigned CPU_W        = 4,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h5A1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [SHARED_W-1:0] cfg_shared_lines,
    input  logic [CPU_W-1:0]    cfg_cpus_online,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                dist_enable,
    output logic                wake_all
);

    localparam logic [31:0] IDENT_WORD = {PRODUCT_CODE, 12'h000, IMPL_CODE};

    reg_sel_e    sel;
    logic [31:0] type_word;
    logic [31:0] rd_word;
    ctl_state_t  st_d, st_q;

    // Address bits outside [3:2] and write-data bits above 0 take no part.
    logic addr_unused;
    logic wdata_unused;
    assign addr_unused  = ^{req_addr[ADDR_W-1:4], req_addr[1:0]};
    assign wdata_unused = ^req_wdata[31:1];

    dist_ctl_decode u_decode (
        .word_sel (req_addr[3:2]),
        .sel      (sel)
    );

    dist_ctl_typeval #(
        .SHARED_W (SHARED_W),
        .CPU_W    (CPU_W)
    ) u_typeval (
        .shared_lines (cfg_shared_lines),
        .cpus_online  (cfg_cpus_online),
        .type_word    (type_word)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL:  rd_word = {31'b0, st_q.en};
            SEL_TYPE:  rd_word = type_word;
            SEL_IDENT: rd_word = IDENT_WORD;
            default:   rd_word = 32'b0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.wake      = 1'b0;
        st_d.rsp_valid = 1'b0;
        if (req_valid) begin
            if (req_write) begin
                if (sel == SEL_CTRL) begin
                    st_d.en   = req_wdata[0];
                    st_d.wake = req_wdata[0] & ~st_q.en;
                end
            end else begin
                st_d.rsp_valid = 1'b1;
                st_d.rdata     = rd_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dist_enable = st_q.en;
    assign wake_all    = st_q.wake;
    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_rdata   = st_q.rdata;

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_all |=> !wake_all); // R4
    AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_all |-> (dist_enable && !$past(dist_enable))); // R4
    AST_EN_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(dist_enable)); // R3
    AST_NONCTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[3:2] != 2'd0) |=> ($stable(dist_enable) && !wake_all)); // R8
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R10
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R10

endmodule

// File: tb/sim_dist_ctl_regs.sv
module sim_dist_ctl_regs;

    localparam logic [7:0]  PCODE = 8'h4B;
    localparam logic [11:0] ICODE = 12'h5A1;
    localparam logic [31:0] EXP_ID = 32'h4B0005A1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [9:0]  cfg_shared_lines = 10'd0;
    logic [3:0]  cfg_cpus_online = 4'd1;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        dist_enable;
    logic        wake_all;

    int n_checks = 0;
    int n_fail   = 0;
    logic wake_seen;

    always #4 clk = ~clk;

    dist_ctl_regs #(
        .PRODUCT_CODE (PCODE),
        .IMPL_CODE    (ICODE)
    ) u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_write        (req_write),
        .req_addr         (req_addr),
        .req_wdata        (req_wdata),
        .cfg_shared_lines (cfg_shared_lines),
        .cfg_cpus_online  (cfg_cpus_online),
        .rsp_valid        (rsp_valid),
        .rsp_rdata        (rsp_rdata),
        .dist_enable      (dist_enable),
        .wake_all         (wake_all)
    );

    // {shared lines, cpus online, expected type word}
    localparam logic [45:0] TYPE_VEC [6] = '{
        {10'd0,   4'd1, 32'h00000000},
        {10'd32,  4'd2, 32'h00000021},
        {10'd224, 4'd8, 32'h000000E7},
        {10'd988, 4'd4, 32'h0000007E},
        {10'd96,  4'd3, 32'h00000043},
        {10'd40,  4'd1, 32'h00000001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read strobe for one cycle; data sampled at the following negedge.
    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; v = rsp_valid;
    endtask

    // Write strobe for one cycle; wake_all captured at the following negedge.
    task automatic do_write(input logic [11:0] a, input logic [31:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        wake_seen = wake_all;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check("R2 enable", {31'b0, dist_enable}, 32'd0);
        check("R2 wake", {31'b0, wake_all}, 32'd0);
        check("R2 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        do_read(12'h000, d, v);
        check("R2 ctrl read", d, 32'd0);
        check("R10 read valid", {31'b0, v}, 32'd1);

        // R5 R6: type word over a table of configurations
        for (int i = 0; i < 6; i++) begin
            cfg_shared_lines = TYPE_VEC[i][45:36];
            cfg_cpus_online  = TYPE_VEC[i][35:32];
            do_read(12'h004, d, v);
            check("R5 R6 type word", d, TYPE_VEC[i][31:0]);
        end

        // R7 identification, R9 reserved
        do_read(12'h008, d, v);
        check("R7 ident", d, EXP_ID);
        do_read(12'h00C, d, v);
        check("R9 reserved read", d, 32'd0);

        // R1 aliasing on ignored address bits
        do_read(12'h104, d, v);
        check("R1 alias 0x104 type", d, 32'h00000001);
        do_read(12'h00B, d, v);
        check("R1 low bits 0x00B ident", d, EXP_ID);

        // R3 R4: enable rising edge
        do_write(12'h000, 32'h00000001);
        check("R4 wake on rise", {31'b0, wake_seen}, 32'd1);
        check("R3 enable set", {31'b0, dist_enable}, 32'd1);
        check("R10 no rsp after write", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        check("R4 wake one cycle", {31'b0, wake_all}, 32'd0);
        do_read(12'h000, d, v);
        check("R3 ctrl read", d, 32'd1);

        // R4: write 1 while enabled, no pulse
        do_write(12'h000, 32'hFFFFFFFF);
        check("R4 no wake when enabled", {31'b0, wake_seen}, 32'd0);

        // R3: only bit 0 matters
        do_write(12'h000, 32'hFFFFFFFE);
        check("R3 disable via bit0", {31'b0, dist_enable}, 32'd0);
        check("R4 no wake on clear", {31'b0, wake_seen}, 32'd0);

        // R8: writes to other words ignored
        do_write(12'h004, 32'hFFFFFFFF);
        check("R8 type write enable", {31'b0, dist_enable}, 32'd0);
        check("R8 type write wake", {31'b0, wake_seen}, 32'd0);
        do_write(12'h008, 32'h00000001);
        check("R8 ident write enable", {31'b0, dist_enable}, 32'd0);
        do_write(12'h00C, 32'h00000001);
        check("R8 rsvd write enable", {31'b0, dist_enable}, 32'd0);
        check("R8 rsvd write wake", {31'b0, wake_seen}, 32'd0);
        do_read(12'h004, d, v);
        check("R8 type unchanged", d, 32'h00000001);
        do_read(12'h008, d, v);
        check("R8 ident unchanged", d, EXP_ID);

        // R1: aliased control write
        do_write(12'h100, 32'h00000001);
        check("R1 alias ctrl write enable", {31'b0, dist_enable}, 32'd1);
        check("R4 alias ctrl wake", {31'b0, wake_seen}, 32'd1);

        // R10: idle gives no response
        @(negedge clk);
        check("R10 idle no rsp", {31'b0, rsp_valid}, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule